// File: doc/BRIEF.md
# Temperature Event Comparator with Hysteresis

This block watches a stream of digitised temperature samples and decides when a thermal event must be signalled. Each accepted sample is compared against three programmable limits: a critical limit and the upper and lower edges of an alarm window. The result is three trip-status bits that firmware can read. Tripped conditions release only after the temperature has moved back past the limit by a selectable hysteresis margin.

A four-state event machine turns the status bits into one event output. The states are `EV_QUIET` (nothing asserted), `EV_ACTIVE` (comparator mode, a trip holds), `EV_LATCHED` (interrupt mode, waiting for a clear) and `EV_CRITICAL` (critical override). The machine re-evaluates every clock cycle from the registered status:
- output disabled → `EV_QUIET`
- else critical status set → `EV_CRITICAL`
- else in comparator mode → `EV_ACTIVE` when an enabled window trip holds, otherwise `EV_QUIET`
- else, on a window crossing with critical-only off → `EV_LATCHED`
- else `EV_LATCHED` stays until a clear request moves it to `EV_QUIET`, and `EV_QUIET`, `EV_ACTIVE` and `EV_CRITICAL` all fall to `EV_QUIET`

The pin level is then set by the selected polarity. The surrounding register file supplies the limits and the configuration. The sampling converter supplies the samples.

Top module: `temp_event_unit`

## Requirements
- R1: The sample is 13-bit two's complement at 1/16 °C per LSB. Each limit is an 11-bit two's complement value at 1/4 °C per LSB. Sample bits [1:0] take no part in any comparison. Comparisons are signed, so negative temperatures compare correctly.
- R2: `st_crit` sets when the sample is greater than or equal to the critical limit.
- R3: `st_above` sets when the sample is strictly greater than the upper limit.
- R4: `st_below` sets when the sample is strictly less than the lower limit.
- R5: `cfg_hyst` selects the release margin H: 00 = 0, 01 = 24 LSB (1.5 °C), 10 = 48 LSB (3 °C), 11 = 96 LSB (6 °C). A set above-type bit clears only when the sample is at or below its limit minus H. A set below bit clears only when the sample is at or above the lower limit plus H.
- R6: Status bits change only on a clock edge where `smp_valid` is 1. After reset, all status bits and the event are 0.
- R7: With `cfg_int_mode` = 0 (comparator mode), the event is asserted exactly while an enabled trip holds. `clr_evt` has no effect in this mode.
- R8: With `cfg_int_mode` = 1 (interrupt mode), any change of the {above, below} pair on an accepted sample asserts the event. The event then stays asserted until a `clr_evt` pulse, and stays clear until the next crossing.
- R9: While `st_crit` is 1, the event is asserted in either mode and `clr_evt` cannot release it. Once `st_crit` falls, the programmed mode governs again, with no latched interrupt left over.
- R10: With `cfg_crit_only` = 1, window trips and window crossings never assert the event. Only the critical condition does.
- R11: With `cfg_out_en` = 0, the event is never asserted, one edge after the enable drops.
- R12: `evt_pin` equals `evt_active` when `cfg_act_high` = 1 and its inverse when `cfg_act_high` = 0.
- R13: While `cfg_shutdown` = 1, samples are ignored and no new trip or event arises from them.
- R14: Status bits change on the edge that accepts the sample. The event output follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_temp | input | 13 | Signed sample, 1/16 °C per LSB |
| lim_hi | input | 11 | Upper window limit, signed, 1/4 °C per LSB |
| lim_lo | input | 11 | Lower window limit, signed, 1/4 °C per LSB |
| lim_crit | input | 11 | Critical limit, signed, 1/4 °C per LSB |
| cfg_hyst | input | 2 | Hysteresis select |
| cfg_int_mode | input | 1 | 1 = interrupt mode, 0 = comparator mode |
| cfg_act_high | input | 1 | 1 = active-high pin, 0 = active-low pin |
| cfg_crit_only | input | 1 | Only critical trips raise the event |
| cfg_out_en | input | 1 | Event output enable |
| cfg_shutdown | input | 1 | Ignore samples |
| clr_evt | input | 1 | Clear a latched interrupt (one-cycle pulse) |
| st_crit | output | 1 | At or above critical limit |
| st_above | output | 1 | Above alarm window |
| st_below | output | 1 | Below alarm window |
| evt_pin | output | 1 | Event pin level after polarity |
| evt_active | output | 1 | Event currently asserted |

## Verification
A wrong hysteresis or comparison state shows on the status bits on the very edge that accepts the next sample. It shows either as a bit that fails to release at the margin or as one that sets at the equal value. A wrong event state shows on `evt_active` and `evt_pin` one edge later. Typical symptoms are a latch that survives a clear, a critical event that a clear can drop, or a latch still present after a critical episode ends. The directed scenarios sample each of these at the exact edge where the port must move.

// File: rtl/tev_pkg.sv
package tev_pkg;

    typedef enum logic [1:0] {
        EV_QUIET    = 2'd0,
        EV_ACTIVE   = 2'd1,
        EV_LATCHED  = 2'd2,
        EV_CRITICAL = 2'd3
    } ev_state_t;

    typedef enum logic [1:0] {
        TRIP_AT_OR_ABOVE = 2'd0,
        TRIP_ABOVE       = 2'd1,
        TRIP_BELOW       = 2'd2
    } trip_kind_t;

    typedef struct packed {
        logic crit;
        logic above;
        logic below;
    } trip_status_t;

endpackage

// File: rtl/tev_limit_cmp.sv
module tev_limit_cmp #(
    parameter int                  CW   = 15,
    parameter tev_pkg::trip_kind_t KIND = tev_pkg::TRIP_ABOVE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eval,
    input  logic signed [CW-1:0] temp,
    input  logic signed [CW-1:0] thresh,
    input  logic signed [CW-1:0] hyst,
    output logic                 trip_next,
    output logic                 trip_q
);
    import tev_pkg::*;

    logic signed [CW-1:0] release_pt;
    logic                 set_c;
    logic                 hold_c;

    // set condition decides entry, hold condition keeps a set trip alive
    always_comb begin
        case (KIND)
            TRIP_AT_OR_ABOVE: begin
                release_pt = thresh - hyst;
                set_c      = (temp >= thresh);
                hold_c     = (temp > release_pt);
            end
            TRIP_ABOVE: begin
                release_pt = thresh - hyst;
                set_c      = (temp > thresh);
                hold_c     = (temp > release_pt);
            end
            default: begin
                release_pt = thresh + hyst;
                set_c      = (temp < thresh);
                hold_c     = (temp < release_pt);
            end
        endcase
        trip_next = eval ? (set_c | (trip_q & hold_c)) : trip_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trip_q <= 1'b0;
        else        trip_q <= trip_next;
    end

endmodule

// File: rtl/tev_trip.sv
module tev_trip #(
    parameter int SMP_W     = 13,
    parameter int LIM_W     = 11,
    parameter int HYST_UNIT = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic                  shutdown,
    input  logic [SMP_W-1:0]      smp_temp,
    input  logic [LIM_W-1:0]      lim_hi,
    input  logic [LIM_W-1:0]      lim_lo,
    input  logic [LIM_W-1:0]      lim_crit,
    input  logic [1:0]            hyst_sel,
    output tev_pkg::trip_status_t status,
    output logic                  win_chg
);
    import tev_pkg::*;

    localparam int SHIFT  = SMP_W - LIM_W;
    localparam int CW     = SMP_W + 2;
    localparam int EXT    = CW - SMP_W;
    localparam int N_TRIP = 3;

    logic                 eval;
    logic [SMP_W-1:0]     temp_al;
    logic signed [CW-1:0] temp_c;
    logic signed [CW-1:0] hyst_c;
    logic [SMP_W-1:0]     thr_raw [N_TRIP];
    logic signed [CW-1:0] thr_c   [N_TRIP];
    logic [N_TRIP-1:0]    trip_n;
    logic [N_TRIP-1:0]    trip_q;

    assign eval    = smp_valid & ~shutdown;
    // drop the fraction bits the limits cannot express
    assign temp_al = smp_temp & {{LIM_W{1'b1}}, {SHIFT{1'b0}}};
    assign temp_c  = {{EXT{temp_al[SMP_W-1]}}, temp_al};

    assign thr_raw[0] = {lim_crit, {SHIFT{1'b0}}};
    assign thr_raw[1] = {lim_hi,   {SHIFT{1'b0}}};
    assign thr_raw[2] = {lim_lo,   {SHIFT{1'b0}}};

    always_comb begin
        case (hyst_sel)
            2'd0:    hyst_c = '0;
            2'd1:    hyst_c = CW'(HYST_UNIT);
            2'd2:    hyst_c = CW'(HYST_UNIT * 2);
            default: hyst_c = CW'(HYST_UNIT * 4);
        endcase
    end

    for (genvar g = 0; g < N_TRIP; g++) begin : g_trip
        localparam trip_kind_t K = (g == 0) ? TRIP_AT_OR_ABOVE :
                                   (g == 1) ? TRIP_ABOVE : TRIP_BELOW;
        assign thr_c[g] = {{EXT{thr_raw[g][SMP_W-1]}}, thr_raw[g]};
        tev_limit_cmp #(.CW(CW), .KIND(K)) u_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .eval      (eval),
            .temp      (temp_c),
            .thresh    (thr_c[g]),
            .hyst      (hyst_c),
            .trip_next (trip_n[g]),
            .trip_q    (trip_q[g])
        );
    end

    // window crossing: the above/below pair changes on an accepted sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_chg <= 1'b0;
        else        win_chg <= eval && (trip_n[2:1] != trip_q[2:1]);
    end

    assign status.crit  = trip_q[0];
    assign status.above = trip_q[1];
    assign status.below = trip_q[2];

endmodule

// File: rtl/tev_event_fsm.sv
module tev_event_fsm (
    input  logic                  clk,
    input  logic                  rst_n,
    input  tev_pkg::trip_status_t status,
    input  logic                  win_chg,
    input  logic                  int_mode,
    input  logic                  crit_only,
    input  logic                  out_en,
    input  logic                  clr,
    output logic                  evt_active
);
    import tev_pkg::*;

    ev_state_t state_q;
    ev_state_t state_n;

    always_comb begin
        state_n = state_q;
        if (!out_en) begin
            state_n = EV_QUIET;
        end else if (status.crit) begin
            state_n = EV_CRITICAL;
        end else if (!int_mode) begin
            state_n = (!crit_only && (status.above || status.below)) ? EV_ACTIVE : EV_QUIET;
        end else if (win_chg && !crit_only) begin
            state_n = EV_LATCHED;
        end else begin
            unique case (state_q)
                EV_LATCHED:  state_n = clr ? EV_QUIET : EV_LATCHED;
                EV_QUIET:    state_n = EV_QUIET;
                EV_ACTIVE:   state_n = EV_QUIET;
                EV_CRITICAL: state_n = EV_QUIET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_QUIET;
        else        state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            EV_QUIET:    evt_active = 1'b0;
            EV_ACTIVE:   evt_active = 1'b1;
            EV_LATCHED:  evt_active = 1'b1;
            EV_CRITICAL: evt_active = 1'b1;
        endcase
    end

endmodule

// File: rtl/temp_event_unit.sv
module temp_event_unit #(
    parameter int SMP_W     = 13,
    parameter int LIM_W     = 11,
    parameter int HYST_UNIT = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_temp,
    input  logic [LIM_W-1:0] lim_hi,
    input  logic [LIM_W-1:0] lim_lo,
    input  logic [LIM_W-1:0] lim_crit,
    input  logic [1:0]       cfg_hyst,
    input  logic             cfg_int_mode,
    input  logic             cfg_act_high,
    input  logic             cfg_crit_only,
    input  logic             cfg_out_en,
    input  logic             cfg_shutdown,
    input  logic             clr_evt,
    output logic             st_crit,
    output logic             st_above,
    output logic             st_below,
    output logic             evt_pin,
    output logic             evt_active
);
    import tev_pkg::*;

    trip_status_t status;
    logic         win_chg;

    tev_trip #(.SMP_W(SMP_W), .LIM_W(LIM_W), .HYST_UNIT(HYST_UNIT)) u_trip (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .shutdown  (cfg_shutdown),
        .smp_temp  (smp_temp),
        .lim_hi    (lim_hi),
        .lim_lo    (lim_lo),
        .lim_crit  (lim_crit),
        .hyst_sel  (cfg_hyst),
        .status    (status),
        .win_chg   (win_chg)
    );

    tev_event_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .status     (status),
        .win_chg    (win_chg),
        .int_mode   (cfg_int_mode),
        .crit_only  (cfg_crit_only),
        .out_en     (cfg_out_en),
        .clr        (clr_evt),
        .evt_active (evt_active)
    );

    assign st_crit  = status.crit;
    assign st_above = status.above;
    assign st_below = status.below;
    assign evt_pin  = cfg_act_high ? evt_active : ~evt_active;

endmodule

// File: rtl/tev_checker.sv
module tev_checker (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic cfg_shutdown,
    input logic cfg_int_mode,
    input logic cfg_crit_only,
    input logic cfg_out_en,
    input logic clr_evt,
    input logic st_crit,
    input logic st_above,
    input logic st_below,
    input logic evt_active
);
    // R6 / R13: status frozen unless a sample is accepted
    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && !cfg_shutdown) |=> $stable({st_crit, st_above, st_below}));

    // R11: disabled output is quiet on the next cycle
    p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_out_en |=> !evt_active);

    // R9: critical status forces the event
    p_crit_forces_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_crit && cfg_out_en) |=> evt_active);

    // R7: comparator mode follows an enabled window trip
    p_cmp_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_int_mode && cfg_out_en && !cfg_crit_only && (st_above || st_below)) |=> evt_active);

    // R8: a latched interrupt holds until cleared
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_int_mode && $past(cfg_int_mode) && cfg_out_en && evt_active && !clr_evt
         && !st_crit && !$past(st_crit)) |=> evt_active);
endmodule

bind temp_event_unit tev_checker u_tev_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .smp_valid     (smp_valid),
    .cfg_shutdown  (cfg_shutdown),
    .cfg_int_mode  (cfg_int_mode),
    .cfg_crit_only (cfg_crit_only),
    .cfg_out_en    (cfg_out_en),
    .clr_evt       (clr_evt),
    .st_crit       (st_crit),
    .st_above      (st_above),
    .st_below      (st_below),
    .evt_active    (evt_active)
);

// File: tb/temp_event_unit_bench.sv
`timescale 1ns/1ps
module temp_event_unit_bench;
    localparam int WDOG = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [12:0] smp_temp;
    logic [10:0] lim_hi, lim_lo, lim_crit;
    logic [1:0]  cfg_hyst;
    logic        cfg_int_mode, cfg_act_high, cfg_crit_only, cfg_out_en, cfg_shutdown;
    logic        clr_evt;
    logic        st_crit, st_above, st_below, evt_pin, evt_active;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    temp_event_unit u_temp_event_unit (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .lim_crit(lim_crit), .cfg_hyst(cfg_hyst),
        .cfg_int_mode(cfg_int_mode), .cfg_act_high(cfg_act_high),
        .cfg_crit_only(cfg_crit_only), .cfg_out_en(cfg_out_en),
        .cfg_shutdown(cfg_shutdown), .clr_evt(clr_evt),
        .st_crit(st_crit), .st_above(st_above), .st_below(st_below),
        .evt_pin(evt_pin), .evt_active(evt_active)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_st(input string req, input logic c, input logic a, input logic b);
        chk(req, "status{crit,above,below}", {29'd0, st_crit, st_above, st_below}, {29'd0, c, a, b});
    endtask

    task automatic chk_ev(input string req, input logic e);
        chk(req, "evt_active", {31'd0, evt_active}, {31'd0, e});
    endtask

    // sample accepted on one edge; status and event both settled on return
    task automatic push(input int t);
        @(negedge clk); smp_temp = 13'(t); smp_valid = 1'b1;
        @(negedge clk); smp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); clr_evt = 1'b1;
        @(negedge clk); clr_evt = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // Limits: upper 80 C (320), lower 20 C (80), critical 100 C (400).
    // Sample units: upper 1280, lower 320, critical 1600.

    task automatic t_reset();
        chk_st("R6", 1'b0, 1'b0, 1'b0);
        chk_ev("R6", 1'b0);
        chk("R12", "evt_pin after reset", {31'd0, evt_pin}, 32'd1);
    endtask

    task automatic t_latency();
        @(negedge clk); smp_temp = 13'd1300; smp_valid = 1'b1;
        @(negedge clk); smp_valid = 1'b0;
        chk_st("R14", 1'b0, 1'b1, 1'b0);
        chk_ev("R14", 1'b0);
        @(negedge clk);
        chk_ev("R14", 1'b1);
        smp_temp = 13'd1700;            // no strobe: must be ignored
        repeat (3) @(negedge clk);
        chk_st("R6", 1'b0, 1'b1, 1'b0);
        push(1000);
        chk_ev("R7", 1'b0);
    endtask

    task automatic t_bounds();
        push(1280); chk_st("R3", 1'b0, 1'b0, 1'b0);
        push(1281); chk_st("R1", 1'b0, 1'b0, 1'b0);
        push(1284); chk_st("R3", 1'b0, 1'b1, 1'b0);
        push(320);  chk_st("R4", 1'b0, 1'b0, 1'b0);
        push(319);  chk_st("R4", 1'b0, 1'b0, 1'b1);
        push(1600); chk_st("R2", 1'b1, 1'b1, 1'b0);
        push(1599); chk_st("R2", 1'b0, 1'b1, 1'b0);
        // negative lower limit -10 C = -40 quarter degrees = -160 sample LSB
        lim_lo = 11'(-40);
        push(-161); chk_st("R1", 1'b0, 1'b0, 1'b1);
        push(-157); chk_st("R1", 1'b0, 1'b0, 1'b0);
        lim_lo = 11'd80;
        push(1000); chk_st("R1", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hyst();
        cfg_hyst = 2'b01;
        push(1300); chk_st("R5", 1'b0, 1'b1, 1'b0);
        push(1270); chk_st("R5", 1'b0, 1'b1, 1'b0);
        push(1256); chk_st("R5", 1'b0, 1'b0, 1'b0);
        cfg_hyst = 2'b11;
        push(300);  chk_st("R5", 1'b0, 1'b0, 1'b1);
        push(400);  chk_st("R5", 1'b0, 1'b0, 1'b1);
        push(416);  chk_st("R5", 1'b0, 1'b0, 1'b0);
        cfg_hyst = 2'b10;
        push(1600); chk_st("R5", 1'b1, 1'b1, 1'b0);
        push(1560); chk_st("R5", 1'b1, 1'b1, 1'b0);
        push(1552); chk_st("R5", 1'b0, 1'b1, 1'b0);
        cfg_hyst = 2'b00;
        push(1000); chk_st("R5", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_compare();
        push(1300); chk_ev("R7", 1'b1);
        chk("R12", "evt_pin active low", {31'd0, evt_pin}, 32'd0);
        pulse_clear(); settle();
        chk_ev("R7", 1'b1);
        push(1000); chk_ev("R7", 1'b0);
        chk("R12", "evt_pin idle", {31'd0, evt_pin}, 32'd1);
    endtask

    task automatic t_interrupt();
        cfg_int_mode = 1'b1; settle();
        chk_ev("R8", 1'b0);
        push(1300); chk_ev("R8", 1'b1);
        push(1350); chk_ev("R8", 1'b1);
        pulse_clear(); chk_ev("R8", 1'b0);
        push(1360); chk_ev("R8", 1'b0);
        push(1000); chk_ev("R8", 1'b1);
        pulse_clear(); chk_ev("R8", 1'b0);
        push(300);  chk_ev("R8", 1'b1);
        pulse_clear(); chk_ev("R8", 1'b0);
        push(1000); chk_ev("R8", 1'b1);
        pulse_clear(); chk_ev("R8", 1'b0);
    endtask

    task automatic t_critical();
        push(1700); chk_st("R9", 1'b1, 1'b1, 1'b0);
        chk_ev("R9", 1'b1);
        pulse_clear(); settle();
        chk_ev("R9", 1'b1);
        push(1500); chk_ev("R9", 1'b0);
        push(1000); chk_ev("R9", 1'b1);
        pulse_clear(); chk_ev("R9", 1'b0);
        cfg_int_mode = 1'b0; settle();
    endtask

    task automatic t_crit_only();
        cfg_crit_only = 1'b1;
        push(1300); chk_ev("R10", 1'b0);
        push(1700); chk_ev("R10", 1'b1);
        push(1000); chk_ev("R10", 1'b0);
        cfg_int_mode = 1'b1;
        push(1300); chk_ev("R10", 1'b0);
        push(1000); chk_ev("R10", 1'b0);
        cfg_int_mode = 1'b0;
        cfg_crit_only = 1'b0; settle();
    endtask

    task automatic t_enable();
        cfg_out_en = 1'b0;
        push(1700); chk_st("R11", 1'b1, 1'b1, 1'b0);
        chk_ev("R11", 1'b0);
        chk("R11", "evt_pin disabled", {31'd0, evt_pin}, 32'd1);
        cfg_out_en = 1'b1; settle();
        chk_ev("R11", 1'b1);
        push(1000); chk_ev("R11", 1'b0);
    endtask

    task automatic t_polarity();
        cfg_act_high = 1'b1; settle();
        chk("R12", "evt_pin idle high-pol", {31'd0, evt_pin}, 32'd0);
        push(1300);
        chk("R12", "evt_pin asserted high-pol", {31'd0, evt_pin}, 32'd1);
        push(1000);
        chk("R12", "evt_pin released high-pol", {31'd0, evt_pin}, 32'd0);
        cfg_act_high = 1'b0; settle();
        chk("R12", "evt_pin idle low-pol", {31'd0, evt_pin}, 32'd1);
    endtask

    task automatic t_shutdown();
        cfg_shutdown = 1'b1;
        push(1700); chk_st("R13", 1'b0, 1'b0, 1'b0);
        chk_ev("R13", 1'b0);
        cfg_shutdown = 1'b0;
        push(1700); chk_st("R13", 1'b1, 1'b1, 1'b0);
        chk_ev("R13", 1'b1);
        push(1000); chk_ev("R13", 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_temp = 13'd1000;
        lim_hi = 11'd320; lim_lo = 11'd80; lim_crit = 11'd400;
        cfg_hyst = 2'b00; cfg_int_mode = 1'b0; cfg_act_high = 1'b0;
        cfg_crit_only = 1'b0; cfg_out_en = 1'b1; cfg_shutdown = 1'b0;
        clr_evt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_bounds();
        t_hyst();
        t_compare();
        t_interrupt();
        t_critical();
        t_crit_only();
        t_enable();
        t_polarity();
        t_shutdown();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule